// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block watches two candidate reference clocks and chooses which one feeds a downstream PLL. Each input is sampled in a free-running supervisor clock domain. A per-input activity monitor counts supervisor cycles since that input's last edge. When the count reaches a programmable limit, the input is declared dead. The limit is normally set to about two periods of the reference clock.

A small state machine owns the select line of a two-input clock multiplexer. It moves the select away from a dead input only when the other input is still toggling. It can move in either direction, as often as needed. Each select change produces a one-cycle reset request for the PLL, so that the PLL can re-establish phase. When both inputs are dead, the select is frozen and the per-input flags are marked not valid.

The multiplexer is modelled behaviourally. Correct detection assumes the two input periods are within a factor of two of each other.

Top module: `refclk_failover`

## Requirements
- R1: While input 0 is selected (`sel_o` = 0), if input 0 goes dead and input 1 is alive, `sel_o` becomes 1. Value 0 selects `ref0_i` and value 1 selects `ref1_i`.
- R2: Bit i of `bad_o` refers to input i. Take k as the supervisor edge just after the input's last transition. The bit is still low at edge k+L and high by edge k+L+5, where L is `stuck_limit_i`. The input may stop at either level.
- R3: A flagged input clears its `bad_o` bit once it toggles again, and the select does not change because of that.
- R4: When both inputs are dead, the select does not change, no reset request is issued, and `flags_valid_o` is low. Once either input recovers, `flags_valid_o` returns high.
- R5: There is no limit on the number of switchovers. With input 1 selected, if input 1 goes dead and input 0 is alive, `sel_o` returns to 0.
- R6: `pll_rst_o` is high for exactly one supervisor cycle, starting at the same edge as each change of `sel_o`. It is never high at any other time.
- R7: `active_o` always equals the select, and `ref_clk_o` follows the selected input.
- R8: After reset, `sel_o` = 0, `bad_o` = 0, `flags_valid_o` = 1 and `pll_rst_o` = 0. No input is flagged until both inputs have shown at least one edge.
- R9: If the input that is not selected goes dead, its `bad_o` bit is set, and there is no switchover and no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sup_clk_i | input | 1 | Free-running supervisor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref0_i | input | 1 | Candidate reference clock 0 |
| ref1_i | input | 1 | Candidate reference clock 1 |
| stuck_limit_i | input | CNT_W | Supervisor cycles without an edge before an input counts as dead |
| bad_o | output | 2 | Per-input dead flag, bit i for input i |
| flags_valid_o | output | 1 | Low while both inputs are dead |
| sel_o | output | 1 | Multiplexer select, 0 chooses ref0_i |
| active_o | output | 1 | Index of the input feeding the PLL |
| pll_rst_o | output | 1 | One-cycle PLL reset request on each switchover |
| ref_clk_o | output | 1 | Behavioural multiplexer output |

## Verification
Suppose the select register or the state is corrupted. The fault shows at the ports as a `sel_o` that disagrees with which input is alive. It also shows as a `pll_rst_o` pulse that has no matching select change. Either symptom appears within about L+5 supervisor cycles of a stimulus that should have caused a switchover.

A corrupted edge counter or synchronizer has two possible symptoms. Either a healthy input is flagged, or a stuck input goes unflagged past the R2 window. Either way, the wrong `bad_o` bit is visible by the next check point.

// File: rtl/refclk_failover_pkg.sv
package refclk_failover_pkg;
  localparam int NUM_IN = 2;
  typedef enum logic {ST_ARM, ST_RUN} fo_state_e;
endpackage

// File: rtl/refclk_failover_act.sv
module refclk_failover_act #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             seen_o,
  output logic             dead_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES:0] sync_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 seen_q;
  logic                 edge_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ref_i};
  end

  // extra stage past the synchronizer gives both-edge detection
  assign edge_s = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (edge_s) begin
      cnt_q  <= '0;
      seen_q <= 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign seen_o = seen_q;
  assign dead_o = seen_q && (cnt_q >= limit_i);
endmodule

// File: rtl/refclk_failover_fsm.sv
module refclk_failover_fsm
  import refclk_failover_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              armed_i,
  input  logic [NUM_IN-1:0] dead_i,
  output logic              sel_o,
  output logic              pll_rst_o,
  output logic [NUM_IN-1:0] bad_o,
  output logic              valid_o
);
  fo_state_e         state_q;
  logic              sel_q, pulse_q, valid_q;
  logic [NUM_IN-1:0] bad_q;
  logic              go_s;

  // leave only for a live partner
  assign go_s = dead_i[sel_q] && !dead_i[~sel_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARM;
      sel_q   <= 1'b0;
      pulse_q <= 1'b0;
      bad_q   <= '0;
      valid_q <= 1'b1;
    end else begin
      pulse_q <= 1'b0;
      unique case (state_q)
        ST_ARM: if (armed_i) state_q <= ST_RUN;
        ST_RUN: begin
          bad_q   <= dead_i;
          valid_q <= ~&dead_i;
          if (go_s) begin
            sel_q   <= ~sel_q;
            pulse_q <= 1'b1;
          end
        end
        default: state_q <= ST_ARM;
      endcase
    end
  end

  assign sel_o     = sel_q;
  assign pll_rst_o = pulse_q;
  assign bad_o     = bad_q;
  assign valid_o   = valid_q;
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
  import refclk_failover_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sup_clk_i,
  input  logic             rst_ni,
  input  logic             ref0_i,
  input  logic             ref1_i,
  input  logic [CNT_W-1:0] stuck_limit_i,
  output logic [1:0]       bad_o,
  output logic             flags_valid_o,
  output logic             sel_o,
  output logic             active_o,
  output logic             pll_rst_o,
  output logic             ref_clk_o
);
  logic [NUM_IN-1:0] ref_s, seen, dead;
  logic              armed;

  assign ref_s = {ref1_i, ref0_i};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_act
    refclk_failover_act #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_act (
      .clk_i  (sup_clk_i),
      .rst_ni (rst_ni),
      .ref_i  (ref_s[g]),
      .limit_i(stuck_limit_i),
      .seen_o (seen[g]),
      .dead_o (dead[g])
    );
  end

  assign armed = &seen;

  refclk_failover_fsm u_fsm (
    .clk_i    (sup_clk_i),
    .rst_ni   (rst_ni),
    .armed_i  (armed),
    .dead_i   (dead),
    .sel_o    (sel_o),
    .pll_rst_o(pll_rst_o),
    .bad_o    (bad_o),
    .valid_o  (flags_valid_o)
  );

  assign active_o  = sel_o;
  // behavioural stand-in for a glitch-free clock mux
  assign ref_clk_o = sel_o ? ref1_i : ref0_i;
endmodule

// File: rtl/refclk_failover_chk.sv
module refclk_failover_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       pll_rst_i,
  input logic [1:0] bad_i,
  input logic [1:0] dead_i,
  input logic       armed_i
);
  AST_SWITCH_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_i) |-> $past(dead_i[0] && !dead_i[1])); // R1
  AST_SWITCH_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_i) |-> $past(dead_i[1] && !dead_i[0])); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_i |=> !pll_rst_i); // R6
  AST_PULSE_WITH_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_i |-> (sel_i != $past(sel_i))); // R6
  AST_BOTH_DEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&dead_i) |=> $stable(sel_i)); // R4
  AST_UNARMED_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> (bad_i == 2'b00 && !sel_i)); // R8
endmodule

bind refclk_failover refclk_failover_chk u_chk (
  .clk_i    (sup_clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_o),
  .pll_rst_i(pll_rst_o),
  .bad_i    (bad_o),
  .dead_i   (dead),
  .armed_i  (armed)
);

// File: tb/refclk_failover_test.sv
module refclk_failover_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ref0 = 1'b0, ref1 = 1'b0;
  logic [CNT_W-1:0] limit = 12'd24;
  logic [1:0]       bad_o;
  logic             flags_valid_o, sel_o, active_o, pll_rst_o, ref_clk_o;

  int  vectors = 0, errors = 0, pulses = 0;
  bit  done = 0, pulse_prev = 0;
  bit  run0 = 1, run1 = 0;
  int  h0 = 4, h1 = 5, c0 = 0, c1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refclk_failover #(.CNT_W(CNT_W)) uut (
    .sup_clk_i(clk), .rst_ni(rst_n), .ref0_i(ref0), .ref1_i(ref1),
    .stuck_limit_i(limit), .bad_o(bad_o), .flags_valid_o(flags_valid_o),
    .sel_o(sel_o), .active_o(active_o), .pll_rst_o(pll_rst_o), .ref_clk_o(ref_clk_o)
  );

  // reference clock generators, toggling on negedges
  always @(negedge clk) begin
    if (run0) begin
      if (c0 >= h0 - 1) begin c0 = 0; ref0 = ~ref0; end else c0++;
    end
    if (run1) begin
      if (c1 >= h1 - 1) begin c1 = 0; ref1 = ~ref1; end else c1++;
    end
  end

  // pulse monitor
  always @(negedge clk) begin
    if (rst_n && pll_rst_o) begin
      pulses++;
      if (pulse_prev) begin
        errors++;
        $display("FAIL R6 pll_rst_o high two cycles: act=1 exp=0");
      end
    end
    pulse_prev = rst_n && pll_rst_o;
  end

  task automatic check(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit next_sel(input bit cur, input bit d0, input bit d1);
    if (!cur && d0 && !d1) return 1'b1;
    if (cur && d1 && !d0)  return 1'b0;
    return cur;
  endfunction

  // stop input idx right after it toggles to lvl
  task automatic stop_ref(input int idx, input bit lvl);
    @(posedge clk);
    while (!(idx == 0 ? (ref0 == lvl && c0 == 0) : (ref1 == lvl && c1 == 0)))
      @(posedge clk);
    if (idx == 0) run0 = 0; else run1 = 0;
  endtask

  task automatic start_ref(input int idx);
    @(posedge clk);
    if (idx == 0) begin c0 = 0; run0 = 1; end else begin c1 = 0; run1 = 1; end
  endtask

  initial begin
    int p;
    bit exp_sel;
    // R8 reset state
    wait_n(5);
    check("R8 sel_o after reset", sel_o, 0);
    check("R8 bad_o after reset", bad_o, 0);
    check("R8 flags_valid_o after reset", flags_valid_o, 1);
    check("R8 pll_rst_o after reset", pll_rst_o, 0);
    rst_n = 1'b1;
    wait_n(60);
    check("R8 no flag before both inputs seen", bad_o, 0);
    check("R8 select held before arming", sel_o, 0);
    start_ref(1);
    wait_n(40);
    check("R8 healthy after arming", bad_o, 0);
    check("R7 ref_clk_o follows ref0", ref_clk_o, ref0);

    // input 0 stuck low
    stop_ref(0, 1'b0);
    wait_n(24 + 1);
    check("R2 bad0 not before limit", bad_o[0], 0);
    check("R1 no early switch", sel_o, 0);
    wait_n(5);
    check("R2 bad0 stuck low", bad_o[0], 1);
    check("R1 switched to input 1", sel_o, 1);
    check("R7 active_o", active_o, 1);
    check("R7 ref_clk_o follows ref1", ref_clk_o, ref1);
    check("R6 one pulse", pulses, 1);
    check("R4 flags valid", flags_valid_o, 1);

    // return of input 0, then failure of input 1 (stuck high)
    start_ref(0);
    wait_n(40);
    check("R3 bad0 cleared", bad_o[0], 0);
    check("R3 select unchanged on recovery", sel_o, 1);
    stop_ref(1, 1'b1);
    wait_n(30);
    check("R2 bad1 stuck high", bad_o[1], 1);
    check("R5 switched back to input 0", sel_o, 0);
    check("R6 second pulse", pulses, 2);

    // input 0 stuck high
    start_ref(1);
    wait_n(40);
    check("R3 bad1 cleared", bad_o[1], 0);
    stop_ref(0, 1'b1);
    wait_n(24 + 1);
    check("R2 bad0 high not before limit", bad_o[0], 0);
    wait_n(5);
    check("R2 bad0 stuck high", bad_o[0], 1);
    check("R5 third switchover", sel_o, 1);
    check("R6 third pulse", pulses, 3);
    start_ref(0);
    wait_n(40);

    // non-selected input fails, then both dead
    stop_ref(0, 1'b0);
    wait_n(30);
    check("R9 bad0 on idle input", bad_o[0], 1);
    check("R9 no switch for idle input", sel_o, 1);
    check("R9 no pulse", pulses, 3);
    stop_ref(1, 1'b0);
    wait_n(40);
    check("R4 flags invalid both dead", flags_valid_o, 0);
    check("R4 select frozen both dead", sel_o, 1);
    check("R4 no pulse both dead", pulses, 3);
    start_ref(0);
    wait_n(40);
    check("R4 recovery to live input", sel_o, 0);
    check("R4 flags valid again", flags_valid_o, 1);
    check("R6 pulse on recovery", pulses, 4);
    start_ref(1);
    wait_n(40);

    // random rounds
    void'($urandom(32'h5eed));
    exp_sel = sel_o;
    p = pulses;
    for (int r = 0; r < 8; r++) begin
      int hm, lim;
      bit lvl, nxt;
      h0 = 3 + ($urandom % 4);
      h1 = 3 + ($urandom % 4);
      hm = (h0 > h1) ? h0 : h1;
      lim = 4 * hm;
      limit = lim[CNT_W-1:0];
      wait_n(50);
      check("R3 random healthy flags", bad_o, 0);
      check("R7 random select", sel_o, exp_sel);
      lvl = 1'($urandom % 2);
      stop_ref(exp_sel ? 1 : 0, lvl);
      nxt = next_sel(exp_sel, !exp_sel, exp_sel);
      wait_n(lim + 8);
      check(exp_sel ? "R5 random switch" : "R1 random switch", sel_o, nxt);
      check("R2 random bad flag", bad_o[exp_sel], 1);
      p++;
      check("R6 random pulse count", pulses, p);
      start_ref(exp_sel ? 1 : 0);
      exp_sel = nxt;
    end
    wait_n(50);
    check("R3 final flags", bad_o, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule